// File: doc/BRIEF.md
# Baby-Step Giant-Step Diagonal Matrix-Vector Engine

This block computes y = M·v modulo a prime Q over a cyclic array of N residue slots. It reproduces, on cleartext residues, the rotate-and-multiply dataflow that packed homomorphic schemes use. The slot count is split as N = N1·N2. The engine builds N1 baby-step rotations of the zero-padded input vector once. For each of the N2 giant steps it forms a partial sum of pointwise products between those rotations and N1 stored diagonals. It then rotates the partial sum by g·N1 slots and adds it into the result. That costs about N1+N2 whole-array rotations instead of N.

The matrix is supplied as its N generalized diagonals. Diagonal i, slot j holds M[j][(i+j) mod N]. On each write the storage shifts a giant-step diagonal by -g·N1 slots, so the final rotation lines it up again. The diagonal store and the vector buffer each have two banks. Writes always go to the load bank. An accepted start hands the load bank to the datapath and turns the other bank into the new load bank, so the next operands can be written while a product runs. The datapath has one modular multiplier, one modular adder and one single-cycle barrel rotator. The result leaves one slot per cycle and is followed by a one-cycle done pulse.

The controller's states are:

| State | What it does | Next state |
|---|---|---|
| ST_IDLE | Waits for work | ST_PAD on start |
| ST_PAD | Copies the vector into rotation slot 0, zeroing slots at or above the latched length | ST_BABY when N1 > 1, otherwise ST_MAC |
| ST_BABY | Each cycle stores rotation b as rotation b-1 rotated by one slot | ST_MAC after b = N1-1 |
| ST_MAC | One multiply-accumulate per cycle, with b inner and slot k outer | ST_GROT after the last slot and baby step |
| ST_GROT | Rotates the partial sum by g·N1 | ST_GACC |
| ST_GACC | Adds one slot per cycle into y | ST_MAC for the next giant step, or ST_OUT after the last one |
| ST_OUT | Streams y | ST_DONE after slot N-1 |
| ST_DONE | Raises done for one cycle | ST_IDLE |

Top module: `bsgs_matvec_engine`

## Requirements
- R1: Slots at index s >= vec_len (vec_len latched at start, 0..N) are treated as zero, whatever the vector buffer holds there.
- R2: With dg_sel=i and dg_slot=j carrying M[j][(i+j) mod N], the output slot j equals the sum over c of M[j][c]·v[c], reduced modulo Q.
- R3: Every y_data value is a canonical residue in [0, Q), including when all operands equal Q-1.
- R4: The result is streamed on N consecutive cycles with y_valid high and y_addr going 0,1,...,N-1. y_valid is low at all other times, including after reset.
- R5: done is high for exactly one cycle, the cycle right after slot N-1 is presented. busy falls in the cycle after that. done is low after reset.
- R6: A start that arrives while busy is high has no effect on the running product, its timing, or which bank takes later writes.
- R7: Writes made while busy go to the other bank. They leave the running product unchanged and become the operands of the next start.
- R8: From an accepted start, busy is high for exactly N1 + N2·(N·N1 + N + 1) cycles before the first y_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts a product when the engine is idle |
| vec_len | input | $clog2(N+1) | Count of live vector slots, latched at start |
| vec_we | input | 1 | Vector write strobe (load bank) |
| vec_addr | input | $clog2(N) | Vector slot being written |
| vec_wdata | input | W | Vector residue |
| dg_we | input | 1 | Diagonal write strobe (load bank) |
| dg_sel | input | $clog2(N) | Diagonal number i |
| dg_slot | input | $clog2(N) | Slot j within the diagonal |
| dg_wdata | input | W | Residue M[j][(i+j) mod N] |
| busy | output | 1 | High from the cycle after an accepted start until done |
| done | output | 1 | One-cycle completion pulse |
| y_valid | output | 1 | Result slot present |
| y_addr | output | $clog2(N) | Index of the presented result slot |
| y_data | output | W | Result residue |

## Verification
The bench runs two shapes: N=16 with a 4×4 split, and N=8 with a 2×4 split, where the split is uneven. Wrong giant-step pre-rotation or rotation direction scrambles result slots whenever diagonals beyond the first N1 are nonzero. A missing final subtraction in the modular adder shows up as out-of-range results when every operand is Q-1. Short vector lengths with nonzero junk in the upper slots expose missing padding. A start pulse injected mid-run, followed by loading the next operands during the same run, catches a controller that restarts or flips banks. Either fault corrupts the running product, shifts its latency, or loses the next one.

// File: rtl/bsgs_pkg.sv
package bsgs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PAD,
        ST_BABY,
        ST_MAC,
        ST_GROT,
        ST_GACC,
        ST_OUT,
        ST_DONE
    } bsgs_state_e;

endpackage

// File: rtl/bsgs_modmul.sv
module bsgs_modmul #(
    parameter int W = 16,
    parameter int Q = 65521
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] p
);
    logic [2*W-1:0] prod;

    assign prod = a * b;
    assign p    = W'(prod % (2*W)'(Q));
endmodule

// File: rtl/bsgs_modadd.sv
module bsgs_modadd #(
    parameter int W = 16,
    parameter int Q = 65521
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] s
);
    logic [W:0] raw;

    assign raw = {1'b0, a} + {1'b0, b};
    assign s   = (raw >= (W+1)'(Q)) ? W'(raw - (W+1)'(Q)) : raw[W-1:0];
endmodule

// File: rtl/bsgs_rotator.sv
// Cyclic rotation: the value in slot j moves to slot (j - amt) mod N,
// so output slot s takes input slot (s + amt) mod N.
module bsgs_rotator #(
    parameter int N = 16,
    parameter int W = 16,
    localparam int IW = $clog2(N)
) (
    input  logic [W-1:0]  in_vec  [N],
    input  logic [IW-1:0] amt,
    output logic [W-1:0]  out_vec [N]
);
    for (genvar s = 0; s < N; s++) begin : g_slot
        logic [IW:0] src;
        always_comb begin
            src = (IW+1)'(s) + {1'b0, amt};
            if (src >= (IW+1)'(N)) src = src - (IW+1)'(N);
        end
        assign out_vec[s] = in_vec[src[IW-1:0]];
    end
endmodule

// File: rtl/bsgs_diag_store.sv
// Two-bank diagonal memory. Diagonal i belongs to giant step g = i / N1 and
// is stored rotated by -g*N1: plain slot j lands at (j + g*N1) mod N.
module bsgs_diag_store #(
    parameter int N  = 16,
    parameter int N1 = 4,
    parameter int W  = 16,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          we,
    input  logic          wr_bank,
    input  logic [IW-1:0] wr_diag,
    input  logic [IW-1:0] wr_slot,
    input  logic [W-1:0]  wr_data,
    input  logic          rd_bank,
    input  logic [IW-1:0] rd_diag,
    input  logic [IW-1:0] rd_slot,
    output logic [W-1:0]  rd_data
);
    logic [W-1:0] mem [2][N][N];
    logic [IW:0]  pos_raw;
    logic [IW-1:0] pos;
    int gbase;

    always_comb begin
        gbase   = (int'(wr_diag) / N1) * N1;
        pos_raw = {1'b0, wr_slot} + (IW+1)'(gbase);
        if (pos_raw >= (IW+1)'(N)) pos_raw = pos_raw - (IW+1)'(N);
        pos = pos_raw[IW-1:0];
    end

    always_ff @(posedge clk) begin
        if (we) mem[wr_bank][wr_diag][pos] <= wr_data;
    end

    assign rd_data = mem[rd_bank][rd_diag][rd_slot];
endmodule

// File: rtl/bsgs_matvec_engine.sv
module bsgs_matvec_engine
    import bsgs_pkg::*;
#(
    parameter int N  = 16,
    parameter int N1 = 4,
    parameter int N2 = 4,
    parameter int W  = 16,
    parameter int Q  = 65521,
    localparam int IW = $clog2(N),
    localparam int LW = $clog2(N+1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [LW-1:0] vec_len,
    input  logic          vec_we,
    input  logic [IW-1:0] vec_addr,
    input  logic [W-1:0]  vec_wdata,
    input  logic          dg_we,
    input  logic [IW-1:0] dg_sel,
    input  logic [IW-1:0] dg_slot,
    input  logic [W-1:0]  dg_wdata,
    output logic          busy,
    output logic          done,
    output logic          y_valid,
    output logic [IW-1:0] y_addr,
    output logic [W-1:0]  y_data
);
    localparam int BW = (N1 > 1) ? $clog2(N1) : 1;
    localparam int GW = (N2 > 1) ? $clog2(N2) : 1;

    bsgs_state_e   st_q, st_d;
    logic [BW-1:0] b_q;
    logic [IW-1:0] k_q;
    logic [GW-1:0] g_q;
    logic          cu_bank, ld_bank;
    logic [LW-1:0] len_q;
    logic [W-1:0]  acc_q;

    logic [W-1:0] vbuf [2][N];
    logic [W-1:0] rb   [N1][N];
    logic [W-1:0] pp   [N];
    logic [W-1:0] yy   [N];

    logic last_b, last_k, last_g;
    assign last_b = (int'(b_q) == N1 - 1);
    assign last_k = (int'(k_q) == N - 1);
    assign last_g = (int'(g_q) == N2 - 1);

    // Diagonal read for the current giant/baby step pair
    logic [IW-1:0] dsel;
    logic [W-1:0]  diag_rd;
    assign dsel = IW'(int'(g_q) * N1 + int'(b_q));

    bsgs_diag_store #(.N(N), .N1(N1), .W(W)) u_diag (
        .clk    (clk),
        .we     (dg_we),
        .wr_bank(ld_bank),
        .wr_diag(dg_sel),
        .wr_slot(dg_slot),
        .wr_data(dg_wdata),
        .rd_bank(cu_bank),
        .rd_diag(dsel),
        .rd_slot(k_q),
        .rd_data(diag_rd)
    );

    // Shared rotation unit: baby steps rotate by 1, giant steps by g*N1
    logic [W-1:0]  rot_in  [N];
    logic [W-1:0]  rot_out [N];
    logic [IW-1:0] rot_amt;

    always_comb begin
        for (int s = 0; s < N; s++)
            rot_in[s] = (st_q == ST_BABY) ? rb[BW'(int'(b_q) - 1)][s] : pp[s];
        rot_amt = (st_q == ST_BABY) ? IW'(1) : IW'(int'(g_q) * N1);
    end

    bsgs_rotator #(.N(N), .W(W)) u_rot (
        .in_vec (rot_in),
        .amt    (rot_amt),
        .out_vec(rot_out)
    );

    // Single multiplier and single adder, operands muxed by state
    logic [W-1:0] mul_p, add_a, add_b, add_s;

    bsgs_modmul #(.W(W), .Q(Q)) u_mul (
        .a(diag_rd),
        .b(rb[b_q][k_q]),
        .p(mul_p)
    );

    always_comb begin
        if (st_q == ST_GACC) begin
            add_a = (g_q == '0) ? '0 : yy[k_q];
            add_b = pp[k_q];
        end else begin
            add_a = (b_q == '0) ? '0 : acc_q;
            add_b = mul_p;
        end
    end

    bsgs_modadd #(.W(W), .Q(Q)) u_add (
        .a(add_a),
        .b(add_b),
        .s(add_s)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (start) st_d = ST_PAD;
            ST_PAD:  st_d = (N1 > 1) ? ST_BABY : ST_MAC;
            ST_BABY: if (last_b) st_d = ST_MAC;
            ST_MAC:  if (last_b && last_k) st_d = ST_GROT;
            ST_GROT: st_d = ST_GACC;
            ST_GACC: if (last_k) st_d = last_g ? ST_OUT : ST_MAC;
            ST_OUT:  if (last_k) st_d = ST_DONE;
            ST_DONE: st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // Step counters and bank control
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_q     <= '0;
            k_q     <= '0;
            g_q     <= '0;
            cu_bank <= 1'b0;
            ld_bank <= 1'b0;
            len_q   <= '0;
        end else begin
            case (st_q)
                ST_IDLE: if (start) begin
                    cu_bank <= ld_bank;
                    ld_bank <= ~ld_bank;
                    len_q   <= vec_len;
                    k_q     <= '0;
                    g_q     <= '0;
                    b_q     <= BW'((N1 > 1) ? 1 : 0);
                end
                ST_BABY: b_q <= last_b ? '0 : b_q + 1'b1;
                ST_MAC: begin
                    b_q <= last_b ? '0 : b_q + 1'b1;
                    if (last_b) k_q <= last_k ? '0 : k_q + 1'b1;
                end
                ST_GACC: begin
                    k_q <= last_k ? '0 : k_q + 1'b1;
                    if (last_k && !last_g) g_q <= g_q + 1'b1;
                end
                ST_OUT: k_q <= last_k ? '0 : k_q + 1'b1;
                default: ;
            endcase
        end
    end

    // Data arrays
    always_ff @(posedge clk) begin
        if (vec_we) vbuf[ld_bank][vec_addr] <= vec_wdata;
        case (st_q)
            ST_PAD:
                for (int s = 0; s < N; s++)
                    rb[0][s] <= (s < int'(len_q)) ? vbuf[cu_bank][s] : '0;
            ST_BABY:
                for (int s = 0; s < N; s++) rb[b_q][s] <= rot_out[s];
            ST_MAC:
                if (last_b) pp[k_q] <= add_s;
                else        acc_q   <= add_s;
            ST_GROT:
                for (int s = 0; s < N; s++) pp[s] <= rot_out[s];
            ST_GACC:
                yy[k_q] <= add_s;
            default: ;
        endcase
    end

    // Outputs
    always_comb begin
        busy    = (st_q != ST_IDLE);
        done    = (st_q == ST_DONE);
        y_valid = (st_q == ST_OUT);
        y_addr  = k_q;
        y_data  = yy[k_q];
    end
endmodule

// File: rtl/bsgs_matvec_chk.sv
module bsgs_matvec_chk #(
    parameter int N = 16,
    parameter int W = 16,
    parameter int Q = 65521,
    localparam int IW = $clog2(N)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          y_valid,
    input logic [IW-1:0] y_addr,
    input logic [W-1:0]  y_data
);
    assert_canonical_R3: assert property (@(posedge clk) disable iff (!rst_n)
        y_valid |-> (y_data < W'(Q)));

    assert_first_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(y_valid) |-> (y_addr == '0));

    assert_stream_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (y_valid && (int'(y_addr) != N - 1)) |=> (y_valid && (y_addr == $past(y_addr) + 1'b1)));

    assert_valid_in_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        y_valid |-> busy);

    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    assert_done_after_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(y_valid) && (int'($past(y_addr)) == N - 1)));

    assert_busy_start_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && start) |=> busy);
endmodule

bind bsgs_matvec_engine bsgs_matvec_chk #(.N(N), .W(W), .Q(Q)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .y_valid(y_valid),
    .y_addr (y_addr),
    .y_data (y_data)
);

// File: tb/tb_bsgs_matvec_engine.sv
module bsgs_tb_unit #(
    parameter int N  = 16,
    parameter int N1 = 4,
    parameter int N2 = 4,
    parameter int W  = 16,
    parameter int Q  = 65521
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    output logic finished,
    output int   n_chk,
    output int   n_fail
);
    localparam int IW  = $clog2(N);
    localparam int LW  = $clog2(N+1);
    localparam int LAT = N1 + N2 * (N * N1 + N + 1);

    logic          start, vec_we, dg_we;
    logic [LW-1:0] vec_len;
    logic [IW-1:0] vec_addr, dg_sel, dg_slot;
    logic [W-1:0]  vec_wdata, dg_wdata;
    logic          busy, done, y_valid;
    logic [IW-1:0] y_addr;
    logic [W-1:0]  y_data;

    bsgs_matvec_engine #(.N(N), .N1(N1), .N2(N2), .W(W), .Q(Q)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .vec_len(vec_len),
        .vec_we(vec_we), .vec_addr(vec_addr), .vec_wdata(vec_wdata),
        .dg_we(dg_we), .dg_sel(dg_sel), .dg_slot(dg_slot), .dg_wdata(dg_wdata),
        .busy(busy), .done(done), .y_valid(y_valid), .y_addr(y_addr), .y_data(y_data)
    );

    longint dg [N][N];
    longint vv [N];
    int     ln;
    longint ex [N];
    longint ex_cur [N];

    task automatic chk(input bit ok, input string req, input longint act,
                       input longint expv, input string what);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s (N=%0d) %s: actual %0d expected %0d", req, N, what, act, expv);
        end
    endtask

    // mode 0: random residues; mode 1: every value Q-1
    task automatic gen(input int mode, input int len);
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++)
                dg[i][j] = (mode == 1) ? longint'(Q - 1) : longint'($urandom % Q);
        for (int s = 0; s < N; s++)
            vv[s] = (mode == 1) ? longint'(Q - 1) : longint'($urandom % Q);
        ln = len;
        // Row-by-row reference: M[j][c] sits on diagonal (c - j) mod N, slot j
        for (int j = 0; j < N; j++) begin
            longint acc = 0;
            for (int c = 0; c < ln; c++)
                acc = (acc + dg[(c - j + N) % N][j] * vv[c]) % Q;
            ex[j] = acc;
        end
    endtask

    task automatic load_all();
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++) begin
                @(negedge clk);
                dg_we    = 1'b1;
                dg_sel   = IW'(i);
                dg_slot  = IW'(j);
                dg_wdata = W'(dg[i][j]);
                vec_we   = (i == 0);
                vec_addr = IW'(j);
                vec_wdata = W'(vv[j]);
            end
        @(negedge clk);
        dg_we  = 1'b0;
        vec_we = 1'b0;
    endtask

    // inject 0: plain run; 1: load next operands during run; 2: also a start pulse while busy
    task automatic run_and_check(input int inject, input int next_mode, input int next_len);
        int cnt;
        for (int s = 0; s < N; s++) ex_cur[s] = ex[s];
        @(negedge clk);
        vec_len = LW'(ln);
        start   = 1'b1;
        @(negedge clk);
        start   = 1'b0;
        fork
            begin
                cnt = 0;
                while (!y_valid) begin
                    cnt++;
                    @(negedge clk);
                end
                chk(cnt == LAT, "R8", cnt, LAT, "busy cycles before first y_valid");
                for (int s = 0; s < N; s++) begin
                    chk(y_valid && int'(y_addr) == s, "R4", y_addr, s, "slot order");
                    chk(y_data == W'(ex_cur[s]), (inject != 0) ? "R7" : "R2",
                        y_data, ex_cur[s], "result slot");
                    chk(int'(y_data) < Q, "R3", y_data, Q - 1, "residue range");
                    @(negedge clk);
                end
                chk(done == 1'b1, "R5", done, 1, "done after last slot");
                chk(y_valid == 1'b0, "R4", y_valid, 0, "y_valid after stream");
                @(negedge clk);
                chk(done == 1'b0 && busy == 1'b0, "R5", {done, busy}, 0, "done single pulse");
            end
            begin
                if (inject != 0) begin
                    repeat (3) @(negedge clk);
                    if (inject == 2) begin
                        start = 1'b1;
                        @(negedge clk);
                        start = 1'b0;
                    end
                    gen(next_mode, next_len);
                    load_all();
                end
            end
        join
    endtask

    task automatic t_reset();
        chk(busy == 1'b0, "R5", busy, 0, "busy after reset");
        chk(done == 1'b0, "R5", done, 0, "done after reset");
        chk(y_valid == 1'b0, "R4", y_valid, 0, "y_valid after reset");
    endtask

    task automatic t_random_full();   // R2, R8
        for (int r = 0; r < 2; r++) begin
            gen(0, N);
            load_all();
            run_and_check(0, 0, N);
        end
    endtask

    task automatic t_padding();       // R1
        int lens [3];
        lens[0] = N / 2;
        lens[1] = 1;
        lens[2] = 0;
        for (int r = 0; r < 3; r++) begin
            gen(0, lens[r]);
            load_all();
            run_and_check(0, 0, N);
        end
    endtask

    task automatic t_maxval();        // R3
        gen(1, N);
        load_all();
        run_and_check(0, 0, N);
    endtask

    task automatic t_double_buffer(); // R7
        gen(0, N);
        load_all();
        run_and_check(1, 0, N - 1);
        run_and_check(0, 0, N);
    endtask

    task automatic t_busy_start();    // R6
        gen(0, N);
        load_all();
        run_and_check(2, 0, N);
        run_and_check(0, 0, N);
        chk(busy == 1'b0, "R6", busy, 0, "idle after runs with mid-run start");
    endtask

    initial begin
        finished  = 1'b0;
        n_chk     = 0;
        n_fail    = 0;
        start     = 1'b0;
        vec_len   = '0;
        vec_we    = 1'b0;
        vec_addr  = '0;
        vec_wdata = '0;
        dg_we     = 1'b0;
        dg_sel    = '0;
        dg_slot   = '0;
        dg_wdata  = '0;
        wait (go);
        @(negedge clk);
        t_reset();
        t_random_full();
        t_padding();
        t_maxval();
        t_double_buffer();
        t_busy_start();
        finished = 1'b1;
    end
endmodule

module tb_bsgs_matvec_engine;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic go = 1'b0;
    logic fin_a, fin_b;
    int   chk_a, chk_b, fail_a, fail_b;

    always #2 clk = ~clk;

    bsgs_tb_unit #(.N(16), .N1(4), .N2(4), .W(16), .Q(65521)) u_n16 (
        .clk(clk), .rst_n(rst_n), .go(go), .finished(fin_a), .n_chk(chk_a), .n_fail(fail_a));

    bsgs_tb_unit #(.N(8), .N1(2), .N2(4), .W(8), .Q(251)) u_n8 (
        .clk(clk), .rst_n(rst_n), .go(go), .finished(fin_b), .n_chk(chk_b), .n_fail(fail_b));

    initial begin
        int extra_chk;
        int extra_fail;
        int cyc;
        extra_chk  = 0;
        extra_fail = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        go = 1'b1;
        cyc = 0;
        while (!(fin_a && fin_b) && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        extra_chk = 1;
        if (!(fin_a && fin_b)) begin
            extra_fail = 1;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        end
        $display("End of test - %0d assertions evaluated, %0d failures",
                 chk_a + chk_b + extra_chk, fail_a + fail_b + extra_fail);
        $finish;
    end
endmodule